// File: doc/BRIEF.md
# Control-Transfer Resolver

This block resolves jumps and conditional branches for an integer pipeline. For each decoded control-transfer operation it computes the taken target, evaluates the branch condition, forms the return address for the two jump forms, and checks that the target falls on a four-byte boundary. The check is enabled at run time: it applies only when the compressed-instruction bit of the supplied ISA configuration word is clear.

When a taken transfer lands on a misaligned address with the check enabled, the block reports a synchronous instruction-address-misaligned exception. It then suppresses both the redirect and the return-address write. Every result is registered and appears one clock after the operation is presented. The caller supplies the program counter, the instruction length, both source operands, the sign-extended immediate, the configuration word and a flag saying whether that word could be read.

Top module: `xfer_resolve`

## Requirements
- R1: With `op_valid` high and `op_kind`=0 (direct jump), the next cycle shows `redir_valid`=1 with `redir_target` = `op_pc` + `op_imm`.
- R2: With `op_kind`=1 (register jump), the target is `op_rs1` + `op_imm` with bit 0 of the sum forced to 0.
- R3: Conditional kinds are 2 equal, 3 not-equal, 4 signed less-than, 5 signed greater-or-equal, 6 unsigned less-than and 7 unsigned greater-or-equal, comparing `op_rs1` with `op_rs2`. When the condition is true the target is `op_pc` + `op_imm`. When it is false no output valid is raised.
- R4: A taken target whose bits [1:0] are not both zero, with `isa_valid`=1 and `isa_word` bit 2 clear, raises `exc_valid` with `exc_cause`=0 and `exc_epc` = `exc_tval` = `op_pc`.
- R5: A transfer that raises the exception drives neither `redir_valid` nor `link_valid`.
- R6: With `isa_word` bit 2 set, no exception is raised for any target alignment, and the redirect goes ahead.
- R7: With `isa_valid`=0, the block acts as though `isa_word` bit 2 were set.
- R8: A branch whose condition is false never raises the exception, whatever its target.
- R9: A non-trapping jump (kind 0 or 1) drives `link_valid`=1 with `link_data` = `op_pc` + `op_len`, where the length is 2 or 4 bytes. Branches never raise `link_valid`.
- R10: After reset, and one cycle after any cycle with `op_valid`=0, all three valid outputs are 0. A data output reads 0 whenever its valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_kind | input | 3 | Transfer kind (see R1 to R3) |
| op_pc | input | XLEN | Address of the transfer instruction |
| op_len | input | 3 | Instruction length in bytes |
| op_rs1 | input | XLEN | First source operand |
| op_rs2 | input | XLEN | Second source operand |
| op_imm | input | XLEN | Sign-extended immediate |
| isa_word | input | XLEN | ISA configuration word |
| isa_valid | input | 1 | ISA configuration word could be read |
| redir_valid | output | 1 | Redirect fetch |
| redir_target | output | XLEN | Redirect address |
| link_valid | output | 1 | Write return address |
| link_data | output | XLEN | Return address |
| exc_valid | output | 1 | Misaligned-target exception |
| exc_cause | output | CAUSE_W | Exception cause code |
| exc_epc | output | XLEN | Faulting instruction address |
| exc_tval | output | XLEN | Trap value |

## Verification
The bench targets register jumps whose sum has bit 0 set. A design that failed to clear that bit would trap on a legal target, or would redirect to an odd address. It drives taken targets with only bit 1 set under each setting of the compressed bit and of the readable flag. These catch a check that ignores the configuration, a check that tests only bit 0, and an unreadable word wrongly treated as "no compressed". It also sends not-taken branches and trapping jumps with misaligned targets, to expose a spurious exception, a leaked return-address write or a redirect that goes out anyway. Signed and unsigned comparisons are run with operands of opposite sign, where swapped comparators give the opposite verdict.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
   typedef enum logic [2:0] {
      K_JDIR = 3'd0,
      K_JREG = 3'd1,
      K_BEQ  = 3'd2,
      K_BNE  = 3'd3,
      K_BLT  = 3'd4,
      K_BGE  = 3'd5,
      K_BLTU = 3'd6,
      K_BGEU = 3'd7
   } xfer_kind_e;

   function automatic logic is_jump(input xfer_kind_e k);
      return (k == K_JDIR) || (k == K_JREG);
   endfunction
endpackage

// File: rtl/xfer_cmp.sv
module xfer_cmp
   import xfer_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  xfer_kind_e        kind,
   input  logic [XLEN-1:0]   a,
   input  logic [XLEN-1:0]   b,
   output logic              taken
);
   logic eq, lts, ltu;

   assign eq  = (a == b);
   assign lts = ($signed(a) < $signed(b));
   assign ltu = (a < b);

   always_comb begin
      unique case (kind)
         K_JDIR, K_JREG: taken = 1'b1;
         K_BEQ:          taken = eq;
         K_BNE:          taken = !eq;
         K_BLT:          taken = lts;
         K_BGE:          taken = !lts;
         K_BLTU:         taken = ltu;
         K_BGEU:         taken = !ltu;
         default:        taken = 1'b0;
      endcase
   end
endmodule

// File: rtl/xfer_addr.sv
module xfer_addr
   import xfer_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int LEN_W = 3
) (
   input  xfer_kind_e        kind,
   input  logic [XLEN-1:0]   pc,
   input  logic [LEN_W-1:0]  len,
   input  logic [XLEN-1:0]   rs1,
   input  logic [XLEN-1:0]   imm,
   output logic [XLEN-1:0]   target,
   output logic [XLEN-1:0]   link
);
   logic [XLEN-1:0] base;
   logic [XLEN-1:0] sum;

   assign base = (kind == K_JREG) ? rs1 : pc;
   assign sum  = base + imm;

   always_comb begin
      target = sum;
      if (kind == K_JREG) target[0] = 1'b0;
   end

   assign link = pc + XLEN'(len);
endmodule

// File: rtl/xfer_align.sv
module xfer_align #(
   parameter int XLEN       = 32,
   parameter int CBIT       = 2,
   parameter bit CHECK_EN   = 1'b1
) (
   input  logic [XLEN-1:0]   target,
   input  logic [XLEN-1:0]   isa_word,
   input  logic              isa_valid,
   output logic              compressed_on,
   output logic              misaligned
);
   initial begin
      assert (CBIT < XLEN) else $error("CBIT outside ISA word");
   end

   assign compressed_on = !isa_valid || isa_word[CBIT];

   generate
      if (CHECK_EN) begin : g_check
         assign misaligned = !compressed_on && (target[1:0] != 2'b00);
      end else begin : g_nocheck
         assign misaligned = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/xfer_resolve.sv
module xfer_resolve
   import xfer_pkg::*;
#(
   parameter int XLEN          = 32,
   parameter int LEN_W         = 3,
   parameter int CAUSE_W       = 6,
   parameter int CBIT          = 2,
   parameter int MISALIGN_CODE = 0,
   parameter bit CHECK_EN      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_valid,
   input  logic [2:0]         op_kind,
   input  logic [XLEN-1:0]    op_pc,
   input  logic [LEN_W-1:0]   op_len,
   input  logic [XLEN-1:0]    op_rs1,
   input  logic [XLEN-1:0]    op_rs2,
   input  logic [XLEN-1:0]    op_imm,
   input  logic [XLEN-1:0]    isa_word,
   input  logic               isa_valid,
   output logic               redir_valid,
   output logic [XLEN-1:0]    redir_target,
   output logic               link_valid,
   output logic [XLEN-1:0]    link_data,
   output logic               exc_valid,
   output logic [CAUSE_W-1:0] exc_cause,
   output logic [XLEN-1:0]    exc_epc,
   output logic [XLEN-1:0]    exc_tval
);
   localparam logic [CAUSE_W-1:0] CAUSE_MIS = CAUSE_W'(MISALIGN_CODE);

   initial begin
      assert (XLEN >= 8) else $error("XLEN too small");
      assert (LEN_W >= 3) else $error("LEN_W cannot hold a length of 4");
      assert (MISALIGN_CODE < (1 << CAUSE_W)) else $error("cause code too wide");
   end

   xfer_kind_e      kind;
   logic            taken, mis, c_on, jump;
   logic [XLEN-1:0] tgt, lnk;
   logic            n_redir, n_link, n_exc;

   assign kind = xfer_kind_e'(op_kind);
   assign jump = is_jump(kind);

   xfer_cmp #(.XLEN(XLEN)) u_cmp (
      .kind(kind), .a(op_rs1), .b(op_rs2), .taken(taken)
   );

   xfer_addr #(.XLEN(XLEN), .LEN_W(LEN_W)) u_addr (
      .kind(kind), .pc(op_pc), .len(op_len), .rs1(op_rs1), .imm(op_imm),
      .target(tgt), .link(lnk)
   );

   xfer_align #(.XLEN(XLEN), .CBIT(CBIT), .CHECK_EN(CHECK_EN)) u_align (
      .target(tgt), .isa_word(isa_word), .isa_valid(isa_valid),
      .compressed_on(c_on), .misaligned(mis)
   );

   assign n_exc   = op_valid && taken && mis;
   assign n_redir = op_valid && taken && !mis;
   assign n_link  = op_valid && jump && !mis;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redir_valid  <= 1'b0;
         redir_target <= '0;
         link_valid   <= 1'b0;
         link_data    <= '0;
         exc_valid    <= 1'b0;
         exc_cause    <= '0;
         exc_epc      <= '0;
         exc_tval     <= '0;
      end else begin
         redir_valid  <= n_redir;
         redir_target <= n_redir ? tgt : '0;
         link_valid   <= n_link;
         link_data    <= n_link ? lnk : '0;
         exc_valid    <= n_exc;
         exc_cause    <= n_exc ? CAUSE_MIS : '0;
         exc_epc      <= n_exc ? op_pc : '0;
         exc_tval     <= n_exc ? op_pc : '0;
      end
   end

   // R5: a trapping transfer neither redirects nor writes a return address
   p_trap_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (!redir_valid && !link_valid));

   // R4: exception reports the faulting address in both fields
   p_exc_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (exc_epc == exc_tval && exc_cause == CAUSE_MIS));

   // R6: a redirect is aligned unless compressed instructions are on
   p_redir_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(redir_valid) |-> ($past(c_on) || redir_target[1:0] == 2'b00));

   // R2: register jump never redirects to an odd address
   p_jreg_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && kind == K_JREG) |=> (!redir_valid || !redir_target[0]));

   // R10: an idle input cycle yields no output the next cycle
   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !(redir_valid || link_valid || exc_valid));

   // R8: a false branch condition never traps
   p_nottaken_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !jump && !taken) |=> !exc_valid);
endmodule

// File: tb/tb_xfer_resolve.sv
module tb_xfer_resolve;
   localparam int XLEN = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic op_valid = 1'b0;
   logic [2:0] op_kind = '0;
   logic [XLEN-1:0] op_pc = '0, op_rs1 = '0, op_rs2 = '0, op_imm = '0, isa_word = '0;
   logic [2:0] op_len = 3'd4;
   logic isa_valid = 1'b1;
   logic redir_valid, link_valid, exc_valid;
   logic [XLEN-1:0] redir_target, link_data, exc_epc, exc_tval;
   logic [5:0] exc_cause;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   xfer_resolve dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .op_pc(op_pc), .op_len(op_len), .op_rs1(op_rs1), .op_rs2(op_rs2),
      .op_imm(op_imm), .isa_word(isa_word), .isa_valid(isa_valid),
      .redir_valid(redir_valid), .redir_target(redir_target),
      .link_valid(link_valid), .link_data(link_data),
      .exc_valid(exc_valid), .exc_cause(exc_cause),
      .exc_epc(exc_epc), .exc_tval(exc_tval)
   );

   localparam logic [XLEN-1:0] C_ON  = 32'h0000_0004;
   localparam logic [XLEN-1:0] C_OFF = 32'h4000_0100;

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   // Reference model written from the requirements; checks all outputs.
   task automatic run_op(input string tag, input logic [2:0] k, input logic [XLEN-1:0] pc,
                         input logic [2:0] len, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                         input logic [XLEN-1:0] imm, input logic [XLEN-1:0] isa, input logic iv);
      logic tk, cen, mis, jmp;
      logic [XLEN-1:0] t;
      @(negedge clk);
      op_kind = k; op_pc = pc; op_len = len; op_rs1 = a; op_rs2 = b;
      op_imm = imm; isa_word = isa; isa_valid = iv; op_valid = 1'b1;
      jmp = (k <= 3'd1);
      case (k)
         3'd0, 3'd1: tk = 1'b1;
         3'd2: tk = (a == b);
         3'd3: tk = (a != b);
         3'd4: tk = ($signed(a) < $signed(b));
         3'd5: tk = !($signed(a) < $signed(b));
         3'd6: tk = (a < b);
         default: tk = !(a < b);
      endcase
      t = (k == 3'd1) ? ((a + imm) & ~32'h1) : (pc + imm);
      cen = !iv || isa[2];
      mis = tk && !cen && (t[1:0] != 2'b00);
      @(negedge clk);
      op_valid = 1'b0;
      chk({tag, " redir_valid"}, 64'(redir_valid), 64'(tk && !mis));
      chk({tag, " redir_target"}, 64'(redir_target), (tk && !mis) ? 64'(t) : 64'd0);
      chk({tag, " link_valid"}, 64'(link_valid), 64'(jmp && !mis));
      chk({tag, " link_data"}, 64'(link_data), (jmp && !mis) ? 64'(pc + 32'(len)) : 64'd0);
      chk({tag, " exc_valid"}, 64'(exc_valid), 64'(mis));
      chk({tag, " exc_cause"}, 64'(exc_cause), 64'd0);
      chk({tag, " exc_epc"}, 64'(exc_epc), mis ? 64'(pc) : 64'd0);
      chk({tag, " exc_tval"}, 64'(exc_tval), mis ? 64'(pc) : 64'd0);
   endtask

   task automatic t_reset();
      chk("R10 reset redir", 64'(redir_valid), 0);
      chk("R10 reset link", 64'(link_valid), 0);
      chk("R10 reset exc", 64'(exc_valid), 0);
   endtask

   task automatic t_direct_jump();
      run_op("R1 jdir fwd", 3'd0, 32'h1000, 3'd4, 0, 0, 32'h40, C_OFF, 1'b1);
      run_op("R1 jdir back", 3'd0, 32'h1000, 3'd4, 0, 0, 32'hFFFF_FFF0, C_OFF, 1'b1);
      run_op("R9 jdir len2", 3'd0, 32'h2002, 3'd2, 0, 0, 32'h10, C_ON, 1'b1);
   endtask

   task automatic t_reg_jump();
      run_op("R2 jreg odd sum", 3'd1, 32'h3000, 3'd4, 32'h501, 0, 32'h4, C_OFF, 1'b1);
      run_op("R4 jreg bit1 trap", 3'd1, 32'h3004, 3'd4, 32'h502, 0, 32'h0, C_OFF, 1'b1);
      run_op("R6 jreg bit1 comp", 3'd1, 32'h3008, 3'd2, 32'h502, 0, 32'h0, C_ON, 1'b1);
   endtask

   task automatic t_branches();
      run_op("R3 beq t", 3'd2, 32'h100, 3'd4, 7, 7, 32'h20, C_OFF, 1'b1);
      run_op("R3 beq n", 3'd2, 32'h100, 3'd4, 7, 8, 32'h20, C_OFF, 1'b1);
      run_op("R3 bne t", 3'd3, 32'h100, 3'd4, 7, 8, 32'h24, C_OFF, 1'b1);
      run_op("R3 blt signed", 3'd4, 32'h100, 3'd4, 32'hFFFF_FFFF, 1, 32'h8, C_OFF, 1'b1);
      run_op("R3 bge signed", 3'd5, 32'h100, 3'd4, 32'hFFFF_FFFF, 1, 32'h8, C_OFF, 1'b1);
      run_op("R3 bltu", 3'd6, 32'h100, 3'd4, 32'hFFFF_FFFF, 1, 32'h8, C_OFF, 1'b1);
      run_op("R3 bgeu", 3'd7, 32'h100, 3'd4, 32'hFFFF_FFFF, 1, 32'h8, C_OFF, 1'b1);
   endtask

   task automatic t_misalign();
      run_op("R4 R5 branch trap", 3'd2, 32'h200, 3'd4, 1, 1, 32'h6, C_OFF, 1'b1);
      run_op("R5 jdir trap", 3'd0, 32'h204, 3'd4, 0, 0, 32'h1, C_OFF, 1'b1);
      run_op("R6 branch comp", 3'd2, 32'h200, 3'd4, 1, 1, 32'h6, C_ON, 1'b1);
      run_op("R7 unreadable", 3'd0, 32'h208, 3'd4, 0, 0, 32'h2, C_OFF, 1'b0);
      run_op("R8 nottaken mis", 3'd3, 32'h20C, 3'd4, 5, 5, 32'h2, C_OFF, 1'b1);
   endtask

   task automatic t_idle();
      @(negedge clk);
      @(negedge clk);
      chk("R10 idle redir", 64'(redir_valid), 0);
      chk("R10 idle link", 64'(link_valid), 0);
      chk("R10 idle exc", 64'(exc_valid), 0);
      chk("R10 idle data", 64'(redir_target | link_data | exc_epc), 0);
   endtask

   task automatic t_random();
      for (int i = 0; i < 300; i++) begin
         logic [XLEN-1:0] isa;
         isa = $urandom();
         run_op("R3 R4 R6 random", 3'($urandom_range(0, 7)), $urandom() & ~32'h1,
                ($urandom_range(0, 1) != 0) ? 3'd4 : 3'd2,
                $urandom_range(0, 3) == 0 ? 32'h10 : $urandom(),
                $urandom_range(0, 3) == 0 ? 32'h10 : $urandom(),
                32'($signed($urandom_range(0, 4095)) - 2048), isa, 1'($urandom_range(0, 3) != 0));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct_jump();
      t_reg_jump();
      t_branches();
      t_misalign();
      t_idle();
      t_random();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule